// File: doc/BRIEF.md
# Leaped Maximal-Length Pseudorandom Word Generator

This block holds a 63-bit linear feedback shift register of maximal length and moves it forward by many single-bit shift positions on every clock. Because the feedback comes from the two highest stages, all of the bits produced during one leap depend only on the register's present contents. They are therefore formed side by side in one cycle, and a new wide pseudorandom word is ready on every clock edge. A typical use is as the noise source for output dither in a word-length reduction stage. Two such words taken on successive cycles, or from two instances, can be summed to shape the noise distribution.

The state can be replaced by a seed through a synchronous load strobe. A seed of zero would lock the register, so it is replaced by a fixed nonzero default. An enable freezes the state when low. Several instances with different seeds can run next to each other and stay independent. A parameter selects how the next state is formed. The direct form writes each new bit as a two-input XOR of current stages. The chained form computes the same function as a walk of serial steps. Both forms give identical sequences.

Top module: `lfsr_leap_gen`

## Requirements
- R1: A synchronous active-high reset sets the state to DEFAULT_SEED (default 63'h2B5A_1234_0F0F_C3C3). Reset takes priority over load and enable.
- R2: In each cycle with enable high and load low, the state advances by exactly STEPS (default 61) serial shifts. One serial shift moves every bit one position toward the MSB (bit 62). It places state[62] XOR state[61] (stages 63 and 62) into bit 0.
- R3: rnd_word[k] equals state bit k for k below min(OUT_W, STEPS). Bit 0 is the most recently generated bit. Any bits above STEPS read zero.
- R4: With enable low and load low, the state and rnd_word stay unchanged.
- R5: With load high, the next state equals seed when seed is nonzero, whatever the value of enable.
- R6: Loading a zero seed sets the state to DEFAULT_SEED.
- R7: Outside reset, the state is never all zero.
- R8: Instances with different seeds each follow their own sequence and do not affect one another.
- R9: The chained next-state form (MODE = LEAP_CHAINED) produces the same sequence as the direct form for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register by STEPS shifts this cycle |
| load | input | 1 | Load the seed this cycle (overrides en) |
| seed | input | STATE_W | Seed value; zero maps to DEFAULT_SEED |
| rnd_word | output | OUT_W | Newest generated bits, bit 0 newest |

## Verification
The bench builds three instances. The first uses the defaults: 48-bit output, 61-step leap, direct form. The second widens the output to 61 bits and takes a separate seed, so nearly the whole state is observed and two instances can be seen to run independently. The third is also 61 bits wide but uses the chained form on the first instance's seed, so the two next-state forms are compared against the same serial reference. The stimulus includes a seed with only the top stage set, an all-ones seed, a zero seed, a load during enable and random enable gaps, checked against a queue-based serial model over about nine thousand cycles.

// File: rtl/lfsr_leap_pkg.sv
package lfsr_leap_pkg;

    localparam int          LFSR_LEN      = 63;
    localparam int          LFSR_TAP_HI   = 63;
    localparam int          LFSR_TAP_LO   = 62;
    localparam int          LFSR_LEAP     = 61;
    localparam int          LFSR_OUT_W    = 48;
    localparam logic [62:0] LFSR_DEF_SEED = 63'h2B5A_1234_0F0F_C3C3;

    typedef enum logic {
        LEAP_DIRECT  = 1'b0,
        LEAP_CHAINED = 1'b1
    } leap_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_RESET = 2'd3
    } lfsr_act_e;

    typedef struct packed {
        lfsr_act_e act;
        logic      upd;
    } lfsr_ctrl_t;

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/lfsr_leap_ctrl.sv
module lfsr_leap_ctrl
    import lfsr_leap_pkg::*;
(
    input  logic       rst,
    input  logic       en,
    input  logic       load,
    output lfsr_ctrl_t ctrl
);

    always_comb begin
        ctrl.act = ACT_HOLD;
        if (rst)       ctrl.act = ACT_RESET;
        else if (load) ctrl.act = ACT_LOAD;
        else if (en)   ctrl.act = ACT_STEP;
        ctrl.upd = (ctrl.act != ACT_HOLD);
    end

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
    parameter int              STATE_W      = 63,
    parameter logic [STATE_W-1:0] DEFAULT_SEED = '1
) (
    input  logic [STATE_W-1:0] seed_in,
    output logic [STATE_W-1:0] seed_ok
);

    logic is_zero;

    assign is_zero = (seed_in == '0);
    assign seed_ok = is_zero ? DEFAULT_SEED : seed_in;

endmodule

// File: rtl/lfsr_leap_next.sv
module lfsr_leap_next
    import lfsr_leap_pkg::*;
#(
    parameter int         STATE_W = 63,
    parameter int         TAP_HI  = 63,
    parameter int         TAP_LO  = 62,
    parameter int         STEPS   = 61,
    parameter leap_mode_e MODE    = LEAP_DIRECT
) (
    input  logic [STATE_W-1:0] cur,
    output logic [STATE_W-1:0] nxt
);

    // Direct form is only valid while every tap read during the leap
    // still refers to an original stage of the current state.
    localparam bit DIRECT_OK = (STEPS <= TAP_LO);
    localparam bit USE_DIRECT = (MODE == LEAP_DIRECT) && DIRECT_OK;

    generate
        if (USE_DIRECT) begin : g_direct
            logic [STEPS-1:0] fresh;
            for (genvar k = 0; k < STEPS; k++) begin : g_bit
                // Step k reads stages that have moved up by k places.
                assign fresh[STEPS-1-k] = cur[TAP_HI-1-k] ^ cur[TAP_LO-1-k];
            end
            assign nxt = {cur[STATE_W-1-STEPS:0], fresh};
        end else begin : g_chained
            always_comb begin
                logic [STATE_W-1:0] walk;
                walk = cur;
                for (int i = 0; i < STEPS; i++) begin
                    walk = {walk[STATE_W-2:0], walk[TAP_HI-1] ^ walk[TAP_LO-1]};
                end
                nxt = walk;
            end
        end
    endgenerate

endmodule

// File: rtl/lfsr_leap_gen.sv
module lfsr_leap_gen
    import lfsr_leap_pkg::*;
#(
    parameter int                 STATE_W      = LFSR_LEN,
    parameter int                 TAP_HI       = LFSR_TAP_HI,
    parameter int                 TAP_LO       = LFSR_TAP_LO,
    parameter int                 STEPS        = LFSR_LEAP,
    parameter int                 OUT_W        = LFSR_OUT_W,
    parameter leap_mode_e         MODE         = LEAP_DIRECT,
    parameter logic [STATE_W-1:0] DEFAULT_SEED = LFSR_DEF_SEED
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               load,
    input  logic [STATE_W-1:0] seed,
    output logic [OUT_W-1:0]   rnd_word
);

    localparam int OUT_EFF = min_int(OUT_W, STEPS);

    lfsr_ctrl_t         ctrl;
    logic [STATE_W-1:0] seed_ok;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_step;
    logic [STATE_W-1:0] state_d;

    lfsr_leap_ctrl u_ctrl (
        .rst  (rst),
        .en   (en),
        .load (load),
        .ctrl (ctrl)
    );

    lfsr_seed_guard #(
        .STATE_W      (STATE_W),
        .DEFAULT_SEED (DEFAULT_SEED)
    ) u_guard (
        .seed_in (seed),
        .seed_ok (seed_ok)
    );

    lfsr_leap_next #(
        .STATE_W (STATE_W),
        .TAP_HI  (TAP_HI),
        .TAP_LO  (TAP_LO),
        .STEPS   (STEPS),
        .MODE    (MODE)
    ) u_next (
        .cur (state_q),
        .nxt (state_step)
    );

    always_comb begin
        unique case (ctrl.act)
            ACT_RESET: state_d = DEFAULT_SEED;
            ACT_LOAD:  state_d = seed_ok;
            ACT_STEP:  state_d = state_step;
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (ctrl.upd) state_q <= state_d;
    end

    generate
        if (OUT_EFF < OUT_W) begin : g_pad
            assign rnd_word = {{(OUT_W-OUT_EFF){1'b0}}, state_q[OUT_EFF-1:0]};
        end else begin : g_full
            assign rnd_word = state_q[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/lfsr_leap_gen_checker.sv
module lfsr_leap_gen_checker #(
    parameter int                 STATE_W      = 63,
    parameter int                 TAP_HI       = 63,
    parameter int                 TAP_LO       = 62,
    parameter int                 STEPS        = 61,
    parameter logic [STATE_W-1:0] DEFAULT_SEED = '1
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               load,
    input logic [STATE_W-1:0] seed,
    input logic [STATE_W-1:0] state_q
);

    AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> state_q[STATE_W-1:STEPS] == $past(state_q[STATE_W-1-STEPS:0])); // R2

    AST_STEP_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> state_q[STEPS-1] == ($past(state_q[TAP_HI-1]) ^ $past(state_q[TAP_LO-1]))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(state_q)); // R4

    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
        (load && seed != '0) |=> state_q == $past(seed)); // R5

    AST_ZERO_SEED_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> state_q == DEFAULT_SEED); // R6

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R7

endmodule

bind lfsr_leap_gen lfsr_leap_gen_checker #(
    .STATE_W      (STATE_W),
    .TAP_HI       (TAP_HI),
    .TAP_LO       (TAP_LO),
    .STEPS        (STEPS),
    .DEFAULT_SEED (DEFAULT_SEED)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (load),
    .seed    (seed),
    .state_q (state_q)
);

// File: tb/lfsr_leap_gen_bench.sv
`timescale 1ns/1ps
module lfsr_leap_gen_bench;
    import lfsr_leap_pkg::*;

    localparam int          SW  = 63;
    localparam logic [62:0] DEF = 63'h2B5A_1234_0F0F_C3C3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst  = 1'b1;
    logic          en   = 1'b0;
    logic          load = 1'b0;
    logic [SW-1:0] seed_a = '0;
    logic [SW-1:0] seed_b = '0;
    logic [47:0]   word_n;
    logic [60:0]   word_c;
    logic [60:0]   word_w;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [62:0] ma = '0;
    logic [62:0] mb = '0;

    lfsr_leap_gen u_lfsr_leap_gen (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed_a), .rnd_word(word_n)
    );

    lfsr_leap_gen #(.OUT_W(61), .MODE(LEAP_CHAINED)) u_chained (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed_a), .rnd_word(word_c)
    );

    lfsr_leap_gen #(.OUT_W(61)) u_second (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed_b), .rnd_word(word_w)
    );

    // Serial reference: queue entry i is stage i+1, entry 0 newest.
    function automatic logic [62:0] serial_leap(input logic [62:0] s);
        bit q[$];
        logic [62:0] r;
        for (int i = 0; i < 63; i++) q.push_back(s[i]);
        for (int n = 0; n < 61; n++) begin
            bit nb;
            nb = q[62] ^ q[61];
            void'(q.pop_back());
            q.push_front(nb);
        end
        for (int i = 0; i < 63; i++) r[i] = q[i];
        return r;
    endfunction

    function automatic logic [62:0] model_next(input logic [62:0] s, input logic [62:0] sd);
        if (rst)       return DEF;
        else if (load) return (sd == '0) ? DEF : sd;
        else if (en)   return serial_leap(s);
        return s;
    endfunction

    task automatic check(input string req, input string inst,
                         input logic [60:0] got, input logic [60:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s inst=%s got=%h exp=%h", req, inst, got, exp);
        end
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        ma = model_next(ma, seed_a);
        mb = model_next(mb, seed_b);
        @(negedge clk);
        if (done) return;
        check({req, "/R3"}, "main",    {13'b0, word_n}, {13'b0, ma[47:0]});
        check({req, "/R9"}, "chained", word_c, ma[60:0]);
        check({req, "/R8"}, "second",  word_w, mb[60:0]);
        if (!rst) check("R7", "model-nonzero", {60'b0, (ma != '0)}, 61'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick("R1");
        // R5: load with enable low
        rst = 1'b0; load = 1'b1;
        seed_a = 63'h4000_0000_0000_0000;
        seed_b = 63'h1357_9BDF_2468_ACE1;
        tick("R5");
        // R2: free-running leaps
        load = 1'b0; en = 1'b1;
        repeat (4000) tick("R2");
        // R4: hold
        en = 1'b0;
        repeat (16) tick("R4");
        // R5: load wins over enable
        load = 1'b1; en = 1'b1;
        seed_a = 63'h7FFF_FFFF_FFFF_FFFF;
        seed_b = 63'h0123_4567_89AB_CDEF;
        tick("R5");
        load = 1'b0;
        // R4/R2: random enable gaps
        for (int i = 0; i < 3000; i++) begin
            en = 1'($urandom_range(0, 1));
            tick("R4");
        end
        // R6: zero seed
        load = 1'b1; en = 1'b0; seed_a = '0; seed_b = '0;
        tick("R6");
        load = 1'b0; en = 1'b1;
        repeat (2000) tick("R2");
        // R1: reset mid-run overrides load
        rst = 1'b1; load = 1'b1; seed_a = 63'h1; seed_b = 63'h2;
        tick("R1");
        rst = 1'b0; load = 1'b0;
        repeat (200) tick("R2");
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule